// File: doc/BRIEF.md
# Break-Before-Make Output Sequencer

This block drives a bank of output channels. Each channel can float, drive the positive rail, drive the negative rail, or drive ground, and each takes its setting from a 2-bit code. The codes of all channels are packed into one word. The caller presents a new target word together with a load strobe. The block then compares each channel's present code with its target. A channel that would swing straight from one rail to the other is not allowed to do so. For every such channel the block first shows an interim word, in which those channels are held at ground. That word stays on the outputs for a dwell time, counted in clock cycles, and then the target word is applied.

The decision for each channel costs one exclusive-OR, of the present code's low bit with the target code's low bit. The interim word is the target word with both bits of every flagged channel set. The block stays busy for the whole dwell. Strobes that arrive during that time are dropped.

Top module: `bbm_output_sequencer`

## Requirements
- R1: Channel i occupies bits [2i+1:2i] of every packed word. The codes are float=00, positive rail=01, negative rail=10, ground=11. The channel count is set by the parameter NCH.
- R2: A channel is flagged for a ground dwell when bit 0 of its present code differs from bit 0 of its target code. Every swing between 01 and 10, in either direction, is therefore flagged.
- R3: A channel whose target equals its present code on the same rail (01 to 01, 10 to 10) is never flagged, and its output holds its code throughout.
- R4: During the dwell the output word equals the target word, with both bits of every flagged channel forced to 1.
- R5: A strobe while idle with no channel flagged puts the target word on the outputs at the next clock edge, and busy stays low.
- R6: A strobe while idle with at least one channel flagged shows the interim word and raises busy at the next edge. The interim word is held for exactly D cycles. At the edge that ends the dwell, the target word appears and busy falls.
- R7: The dwell count D is the value of `dwell_i` sampled at the strobe. A value of 0 is treated as 1. Changes to `dwell_i` after the strobe have no effect.
- R8: A strobe while busy is ignored. Neither the current dwell nor the word applied after it changes, and no further sequence follows.
- R9: The present code used for flagging is updated only when a target word is applied. It is never updated when the interim word is shown.
- R10: A synchronous active-high reset sets every channel to 00 and clears busy.
- R11: No channel of the output word ever goes from 01 to 10, or from 10 to 01, between consecutive clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Strobe that requests a new target word |
| next_word_i | input | 2*NCH | Packed target codes |
| dwell_i | input | DW_W | Ground dwell in cycles, sampled at the strobe |
| out_word_o | output | 2*NCH | Registered packed output codes |
| busy_o | output | 1 | High while the interim word is shown |

## Verification
The hardest case to reach is a strobe that arrives while a dwell is running. It needs a flagged transition, a dwell of the right length, and a second strobe with a conflicting word and dwell, timed to land inside the window and on its final cycle. The bench builds these cases directly. It first steers every channel to a chosen present code, then issues a flagged load, and then injects a poisoned strobe one cycle after the interim word appears. A free-running monitor compares each output word with the one before it, channel by channel, to catch any direct swing between the two rails.

// File: rtl/bbm_pkg.sv
package bbm_pkg;
  localparam logic [1:0] ST_FLOAT = 2'b00;
  localparam logic [1:0] ST_POS   = 2'b01;
  localparam logic [1:0] ST_NEG   = 2'b10;
  localparam logic [1:0] ST_GND   = 2'b11;

  typedef enum logic {PH_IDLE = 1'b0, PH_DWELL = 1'b1} phase_e;
endpackage

// File: rtl/bbm_ground_flags.sv
module bbm_ground_flags #(
  parameter int NCH = 4
) (
  input  logic [2*NCH-1:0] cur_word_i,
  input  logic [2*NCH-1:0] tgt_word_i,
  output logic [NCH-1:0]   flag_o,
  output logic [2*NCH-1:0] interim_o
);
  // one XOR per channel on the low code bits, then OR the flag into both bits
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_comb begin
      flag_o[c]          = cur_word_i[2*c] ^ tgt_word_i[2*c];
      interim_o[2*c]     = tgt_word_i[2*c]   | flag_o[c];
      interim_o[2*c+1]   = tgt_word_i[2*c+1] | flag_o[c];
    end
  end
endmodule

// File: rtl/bbm_dwell_timer.sv
module bbm_dwell_timer #(
  parameter int DW_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic [DW_W-1:0] dwell_i,
  output logic            last_o,
  output logic [DW_W-1:0] cnt_o
);
  logic [DW_W-1:0] cnt_q;
  logic [DW_W-1:0] dwell_eff;

  always_comb begin
    dwell_eff = (dwell_i == '0) ? DW_W'(1) : dwell_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (start_i) begin
      cnt_q <= dwell_eff;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - DW_W'(1);
    end
  end

  assign last_o = (cnt_q == DW_W'(1));
  assign cnt_o  = cnt_q;

  // R7
  timer_decrement_chk: assert property (@(posedge clk) disable iff (rst)
    (!start_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - DW_W'(1)));
endmodule

// File: rtl/bbm_output_sequencer.sv
module bbm_output_sequencer
  import bbm_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int DW_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [2*NCH-1:0]  next_word_i,
  input  logic [DW_W-1:0]   dwell_i,
  output logic [2*NCH-1:0]  out_word_o,
  output logic              busy_o
);
  localparam int WW = 2 * NCH;

  phase_e          phase_q;
  logic [WW-1:0]   cur_q;
  logic [WW-1:0]   tgt_q;
  logic [WW-1:0]   out_q;
  logic [NCH-1:0]  flags;
  logic [WW-1:0]   interim;
  logic            accept;
  logic            start_dwell;
  logic            dwell_last;
  logic [DW_W-1:0] dwell_cnt;

  bbm_ground_flags #(.NCH(NCH)) u_flags (
    .cur_word_i (cur_q),
    .tgt_word_i (next_word_i),
    .flag_o     (flags),
    .interim_o  (interim)
  );

  assign accept      = load_i && (phase_q == PH_IDLE);
  assign start_dwell = accept && (|flags);

  bbm_dwell_timer #(.DW_W(DW_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_dwell),
    .dwell_i (dwell_i),
    .last_o  (dwell_last),
    .cnt_o   (dwell_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cur_q   <= {NCH{ST_FLOAT}};
      tgt_q   <= {NCH{ST_FLOAT}};
      out_q   <= {NCH{ST_FLOAT}};
    end else begin
      case (phase_q)
        PH_IDLE: begin
          if (start_dwell) begin
            tgt_q   <= next_word_i;
            out_q   <= interim;
            phase_q <= PH_DWELL;
          end else if (accept) begin
            cur_q <= next_word_i;
            tgt_q <= next_word_i;
            out_q <= next_word_i;
          end
        end
        PH_DWELL: begin
          if (dwell_last) begin
            cur_q   <= tgt_q;
            out_q   <= tgt_q;
            phase_q <= PH_IDLE;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign out_word_o = out_q;
  assign busy_o     = (phase_q == PH_DWELL);

  // R10
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!busy_o && out_word_o == '0));

  // R8
  busy_hold_target_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !dwell_last) |=> ($stable(tgt_q) && busy_o));

  // R6
  busy_counter_live_chk: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> (dwell_cnt != '0));

  // R9
  cur_only_final_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !dwell_last) |=> $stable(cur_q));

  // R6
  dwell_end_apply_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && dwell_last) |=> (!busy_o && out_word_o == $past(tgt_q)));

  for (genvar c = 0; c < NCH; c++) begin : g_mon
    // R11
    no_rail_swing_chk: assert property (@(posedge clk) disable iff (rst)
      (out_q[2*c+1:2*c] == ST_POS || out_q[2*c+1:2*c] == ST_NEG)
      |=> (out_q[2*c+1:2*c] != ~$past(out_q[2*c+1:2*c])));
  end
endmodule

// File: tb/tb_bbm_output_sequencer.sv
module tb_bbm_output_sequencer;
  localparam int NCH  = 4;
  localparam int DW_W = 8;
  localparam int WW   = 2 * NCH;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            load_i = 1'b0;
  logic [WW-1:0]   next_word_i = '0;
  logic [DW_W-1:0] dwell_i = '0;
  logic [WW-1:0]   out_word_o;
  logic            busy_o;

  int checks = 0;
  int fails  = 0;
  int swings = 0;
  logic [WW-1:0] cur_m = '0;
  logic [WW-1:0] prev_out = '0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bbm_output_sequencer #(.NCH(NCH), .DW_W(DW_W)) dut (
    .clk(clk), .rst(rst), .load_i(load_i), .next_word_i(next_word_i),
    .dwell_i(dwell_i), .out_word_o(out_word_o), .busy_o(busy_o)
  );

  function automatic logic [WW-1:0] model_interim(input logic [WW-1:0] cur,
                                                  input logic [WW-1:0] nx);
    logic [WW-1:0] r = nx;
    for (int c = 0; c < NCH; c++)
      if (cur[2*c] != nx[2*c]) r[2*c+:2] = 2'b11;
    return r;
  endfunction

  function automatic bit model_any(input logic [WW-1:0] cur, input logic [WW-1:0] nx);
    bit a = 1'b0;
    for (int c = 0; c < NCH; c++) a |= (cur[2*c] != nx[2*c]);
    return a;
  endfunction

  task automatic chk(input string req, input logic [WW-1:0] got_w, input logic [WW-1:0] exp_w,
                     input logic got_b, input logic exp_b);
    checks++;
    if (got_w !== exp_w || got_b !== exp_b) begin
      fails++;
      $display("FAIL %s: out=%h busy=%b expected out=%h busy=%b", req, got_w, got_b, exp_w, exp_b);
    end
  endtask

  // R11 monitor: compare each channel with its value one cycle earlier
  always @(negedge clk) begin
    if (!rst) begin
      for (int c = 0; c < NCH; c++)
        if ((prev_out[2*c+:2] == 2'b01 && out_word_o[2*c+:2] == 2'b10) ||
            (prev_out[2*c+:2] == 2'b10 && out_word_o[2*c+:2] == 2'b01)) swings++;
    end
    prev_out = out_word_o;
  end

  task automatic do_load(input logic [WW-1:0] nx, input int dw, input bit poke, input string req);
    logic [WW-1:0] im = model_interim(cur_m, nx);
    bit any = model_any(cur_m, nx);
    int eff = (dw < 1) ? 1 : dw;
    @(negedge clk);
    load_i = 1'b1; next_word_i = nx; dwell_i = DW_W'(dw);
    @(negedge clk);
    load_i = 1'b0;
    if (!any) begin
      chk({req, "/R5"}, out_word_o, nx, busy_o, 1'b0);
    end else begin
      chk({req, "/R4/R6"}, out_word_o, im, busy_o, 1'b1);
      if (poke) begin  // R8 R7: conflicting strobe and dwell during the dwell
        load_i = 1'b1; next_word_i = ~nx; dwell_i = 8'd40;
      end
      for (int k = 1; k < eff; k++) begin
        @(negedge clk);
        load_i = 1'b0;
        chk({req, "/R6 hold"}, out_word_o, im, busy_o, 1'b1);
      end
      @(negedge clk);
      load_i = 1'b0;
      chk({req, "/R6 final"}, out_word_o, nx, busy_o, 1'b0);
      if (poke) begin
        @(negedge clk);
        chk({req, "/R8 ignored"}, out_word_o, nx, busy_o, 1'b0);
      end
    end
    cur_m = nx;
  endtask

  initial begin
    #(4 * 200000);
    fails++; checks++;
    $display("FAIL watchdog: out=%h busy=%b expected out=done busy=0", out_word_o, busy_o);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R10 reset", out_word_o, '0, busy_o, 1'b0);

    // R1 R2 R3: all 16 present/target pairs on every channel
    for (int p = 0; p < 4; p++)
      for (int n = 0; n < 4; n++) begin
        do_load({NCH{p[1:0]}}, 2, 1'b0, "R1 preset");
        do_load({NCH{n[1:0]}}, 3, 1'b0, "R2 R3 pair");
      end

    // mixed channel patterns: only channel 1 swings
    do_load(8'b01_10_10_01, 2, 1'b0, "R1 mix a");
    do_load(8'b01_10_01_01, 3, 1'b0, "R2 single");
    do_load(8'b01_10_01_01, 5, 1'b0, "R3 same");

    // R7: dwell of zero acts as one, dwell of one, long dwell
    do_load(8'b10_01_10_10, 0, 1'b0, "R7 zero");
    do_load(8'b01_10_01_01, 1, 1'b0, "R7 one");
    do_load(8'b10_10_10_10, 7, 1'b0, "R7 seven");

    // R8 R9: strobe during the dwell, also on its last cycle
    do_load(8'b01_01_01_01, 4, 1'b1, "R8 poke");
    do_load(8'b10_10_10_10, 1, 1'b1, "R8 poke last");
    do_load(8'b01_10_01_10, 2, 1'b0, "R9 follow");

    // random traffic
    for (int i = 0; i < 300; i++)
      do_load(WW'($urandom), int'($urandom_range(0, 4)), ($urandom_range(0, 3) == 0), "rand R2 R4");

    // R10: reset mid-dwell
    do_load(8'b00_00_00_00, 1, 1'b0, "R10 pre");
    do_load(8'b01_01_01_01, 5, 1'b0, "R10 pre2");
    @(negedge clk); load_i = 1'b1; next_word_i = 8'b10_10_10_10; dwell_i = 8'd9;
    @(negedge clk); load_i = 1'b0; rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R10 mid reset", out_word_o, '0, busy_o, 1'b0);
    cur_m = '0;

    checks++;
    if (swings != 0) begin
      fails++;
      $display("FAIL R11: out=%0d swings expected out=0 swings", swings);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    done = 1'b1;
    $finish;
  end
endmodule